// File: doc/BRIEF.md
# Power-Down Mode Programming Sequencer

This block sits on the host side of a pseudo-static RAM and produces the six-access unlock sequence that selects the memory's power-down retention mode. A one-cycle start pulse, together with a 2-bit mode selection, launches the run. The block then drives a simple single-access bus. That bus has a request, a read/write flag, an address, write data, read data and a one-cycle acknowledge. An access layer below this block converts each bus access into pin-level strobes.

The run goes as follows. It reads the all-ones address and keeps the returned word. It writes that word back twice and then writes a zero word. Next it writes the data key, and last it reads the address key. The bus request stays low for a fixed number of clock cycles after every acknowledge, which returns the memory to standby between accesses. Once the last standby gap has elapsed, a one-cycle done pulse marks completion. Both keys come from the one mode value that was captured at start.

Top module: `pdprog_seq`

## Requirements
- R1: After reset, busy, done and bus_req are all low, and bus_req stays low whenever busy is low.
- R2: A run makes exactly six accesses, in this order: read, write, write, write, write, read (bus_we high means write).
- R3: Accesses 1 through 5 use the address with every bit set.
- R4: Accesses 2 and 3 write the word that access 1 returned on bus_rdata.
- R5: Access 4 writes the all-zero word.
- R6: Access 5 writes the data key. Its two low bits are 11, 10, 01 or 00 for mode 0 (sleep), 1 (4 Mbit retained), 2 (8 Mbit retained) or 3 (16 Mbit retained), and every higher bit is zero.
- R7: Access 6 reads the address key. The low AW-2 bits are all ones. The top two bits, from the most significant down, are 11 for mode 0, 01 for mode 1, 10 for mode 2 and 00 for mode 3, which gives 1FFFFFh, 0FFFFFh, 17FFFFh and 07FFFFh for AW=21.
- R8: The cycle after an acknowledge, bus_req is low. It then stays low for exactly GAP_CYCLES cycles before the next access begins.
- R9: Busy rises the cycle after an accepted start. Done is a single-cycle pulse, raised GAP_CYCLES+1 cycles after the last acknowledge, and busy falls in the same cycle.
- R10: A start pulse while busy is ignored. The running sequence keeps its original mode, and no further access follows its done.
- R11: While bus_req is high and bus_ack is low, bus_req, bus_we, bus_addr and bus_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch pulse |
| mode | input | 2 | Retention mode selection, sampled with start |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle access completion |

## Verification
The assertions assume the access layer pulses bus_ack only while bus_req is high, and never for two cycles in a row. The bench's bus responder follows that rule. It raises the acknowledge only after it has seen a request for a chosen number of cycles (one to three), and it drops the acknowledge on the next cycle. Start pulses are one cycle wide. The stray start is placed inside a run, where the rules say it must be ignored.

// File: rtl/pdprog_seq.sv
module pdprog_seq #(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int GAP_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack
);
  localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYCLES - 1);
  localparam logic [2:0] LAST_STEP = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GAP} st_t;

  st_t           st;
  logic [2:0]    step;
  logic [CW-1:0] cnt;
  logic [1:0]    mode_q;
  logic [DW-1:0] echo_q;
  logic          done_q;

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign bus_req = (st == S_ACC);
  assign bus_we  = (step != 3'd0) && (step != LAST_STEP);

  always_comb begin
    bus_addr = '1;
    if (step == LAST_STEP) bus_addr = {~mode_q[0], ~mode_q[1], {(AW-2){1'b1}}};
  end

  always_comb begin
    unique case (step)
      3'd1, 3'd2: bus_wdata = echo_q;
      3'd4:       bus_wdata = {{(DW-2){1'b0}}, ~mode_q};
      default:    bus_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      cnt    <= '0;
      mode_q <= '0;
      echo_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st     <= S_ACC;
          step   <= '0;
          mode_q <= mode;
        end
        S_ACC: if (bus_ack) begin
          if (step == 3'd0) echo_q <= bus_rdata;
          st  <= S_GAP;
          cnt <= '0;
        end
        S_GAP: if (cnt == GAP_LAST) begin
          if (step == LAST_STEP) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            step <= step + 3'd1;
            st   <= S_ACC;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdprog_seq_chk.sv
module pdprog_seq_chk #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_req && !bus_we && (&bus_addr)));

  p_drop_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind pdprog_seq pdprog_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/pdprog_seq_tb.sv
module pdprog_seq_tb;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int GAP = 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic [1:0]    mode = 0;
  logic          busy, done, bus_req, bus_we, bus_ack = 0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = 0;

  pdprog_seq #(.AW(AW), .DW(DW), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy), .done(done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bus responder and log
  int          lat = 1, n = 0, wcnt = 0, gcnt = 0, last_ack = 0;
  bit          in_gap = 0;
  logic [DW-1:0] rd_val = 0;
  logic          lw [8];
  logic [AW-1:0] la [8];
  logic [DW-1:0] ld [8];
  int            gaps [8];

  initial forever begin
    @(negedge clk);
    if (bus_ack) begin
      bus_ack = 0;
      in_gap  = 1;
      gcnt    = 1;
      check(!bus_req, "R8 req low after ack", bus_req, 0);
    end else if (bus_req) begin
      if (in_gap && n < 8) gaps[n] = gcnt;
      in_gap = 0;
      wcnt++;
      if (wcnt >= lat) begin
        wcnt = 0;
        if (n < 8) begin
          lw[n] = bus_we; la[n] = bus_addr; ld[n] = bus_wdata;
        end
        n++;
        bus_rdata = rd_val;
        bus_ack   = 1;
        last_ack  = cyc;
      end
    end else if (in_gap) gcnt++;
  end

  task automatic run_seq(input logic [1:0] m, input logic [DW-1:0] rdv, input int l, input bit interfere);
    logic [DW-1:0] dk;
    logic [AW-1:0] ak;
    int done_cyc, k;
    case (m)
      2'd0: begin dk = 16'h0003; ak = 21'h1FFFFF; end
      2'd1: begin dk = 16'h0002; ak = 21'h0FFFFF; end
      2'd2: begin dk = 16'h0001; ak = 21'h17FFFF; end
      default: begin dk = 16'h0000; ak = 21'h07FFFF; end
    endcase
    n = 0; lat = l; rd_val = rdv; in_gap = 0; wcnt = 0;
    @(negedge clk); start = 1; mode = m;
    @(negedge clk); start = 0; mode = ~m;
    check(busy === 1'b1, "R9 busy after start", busy, 1);
    k = 0;
    while (done !== 1'b1 && k < 2000) begin
      if (busy !== 1'b1) check(0, "R9 busy held during run", busy, 1);
      if (interfere && k == 10) start = 1;
      @(negedge clk);
      start = 0;
      k++;
    end
    check(done === 1'b1, "R9 done reached", done, 1);
    done_cyc = cyc;
    check(busy === 1'b0, "R9 busy low with done", busy, 0);
    check(done_cyc - last_ack == GAP + 1, "R9 done delay", done_cyc - last_ack, GAP + 1);
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", done, 0);
    check(n == 6, "R2 access count", n, 6);
    for (int i = 0; i < 6 && i < n; i++) begin
      check(lw[i] == (i != 0 && i != 5), "R2 direction", lw[i], (i != 0 && i != 5));
      if (i < 5) check(la[i] == 21'h1FFFFF, "R3 all-ones address", la[i], 21'h1FFFFF);
      else check(la[i] == ak, "R7 address key", la[i], ak);
      if (i == 1 || i == 2) check(ld[i] == rdv, "R4 echo data", ld[i], rdv);
      if (i == 3) check(ld[i] == 0, "R5 zero word", ld[i], 0);
      if (i == 4) check(ld[i] == dk, "R6 data key", ld[i], dk);
      if (i > 0) check(gaps[i] == GAP, "R8 standby gap", gaps[i], GAP);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!bus_req && !busy, "R10 no extra activity", {bus_req, busy}, 0);
    end
    check(n == 6, "R10 count unchanged", n, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 reset busy", busy, 0);
    check(done === 1'b0, "R1 reset done", done, 0);
    check(bus_req === 1'b0, "R1 reset req", bus_req, 0);
    rst_n = 1;
    @(negedge clk);
    check(bus_req === 1'b0 && busy === 1'b0, "R1 idle after reset", {bus_req, busy}, 0);
    for (int m = 0; m < 4; m++)
      for (int l = 1; l <= 3; l++)
        run_seq(2'(m), 16'hA5C3 ^ 16'(m * 16'h1357 + l * 16'h0F11), l, l == 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #150000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule